// File: doc/BRIEF.md
# Colour Lookup Table Register Block

This block keeps a colour lookup table of 256 entries for a display pipeline. Each entry has its own 8-bit red, green and blue values. Software programs the table through a small window of word-wide registers on a 32-bit memory-mapped bus.

To program the table, software first writes a starting entry number into the pointer register. It then writes colour bytes to the colour register. Each group of three colour writes fills red, green and blue of the current entry, in that order. After the blue write the pointer moves on to the next entry, so a whole run of entries can be streamed without rewriting the pointer. A separate combinational lookup port lets the pixel path read any entry at any time.

The bus side never applies back-pressure. `bus_ready` is held high, so every beat with `bus_valid` high completes in the cycle it is presented. A read beat is answered one cycle later with `bus_rvalid` and a zero data word. The table contents cannot be read back over the bus.

Top module: `clut_ramdac`

## Requirements
- R1: After reset, every entry holds red = green = blue = 0x00, except the last entry (number 255), which holds 0xFF in all three components.
- R2: A write to byte offset 0x0 with all four byte enables set loads the entry pointer from bits 31:24 of the write data. It also restarts the component sequence at red.
- R3: Each accepted write to byte offset 0x4 stores bits 31:24 of the write data into one component of the entry under the pointer. Successive writes go to red, then green, then blue.
- R4: After a blue store the pointer advances by one, wrapping from 255 to 0, and the sequence returns to red.
- R5: Writes to byte offsets 0x8 and 0xC change neither the table, the pointer nor the component sequence.
- R6: A write whose byte enables are not all set, or whose address bits 1:0 are not zero, is ignored in the same way.
- R7: `bus_ready` is always 1. A read beat at any offset raises `bus_rvalid` in the next cycle with `bus_rdata` equal to zero, and it does not disturb the pointer or the sequence.
- R8: `lut_rgb` returns {red[23:16], green[15:8], blue[7:0]} of the entry selected by `lut_idx`, combinationally. A colour store becomes visible there from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus beat present |
| bus_ready | output | 1 | Beat accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| bus_rvalid | output | 1 | Read response, one cycle after a read beat |
| lut_idx | input | 8 | Lookup entry number |
| lut_rgb | output | 24 | Lookup result {R,G,B} |

## Verification
The component phase is never visible at the ports. It only shows up as which byte of which entry the next colour write lands in. The hardest situations are therefore a pointer rewrite, an ignored write or a read arriving in the middle of a red/green/blue triplet, and a blue store on entry 255. Directed sequences set up each of these and then follow them with further colour writes, so that the entry and component those writes land in reveal the hidden phase. A long random mix of all access kinds, checked against a bench model of pointer and phase, then covers the interleavings. Full sweeps of the lookup port close each stage.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int NUM_COMP = 3;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  // component 0 is red, 1 green, 2 blue
  function automatic logic [NUM_COMP-1:0] phase_sel(phase_t p);
    case (p)
      PH_RED:  phase_sel = 3'b001;
      PH_GRN:  phase_sel = 3'b010;
      PH_BLU:  phase_sel = 3'b100;
      default: phase_sel = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int IDX_SLOT = 0,
  parameter int DAT_SLOT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              idx_we,
  output logic              dat_we,
  output logic [IDX_W-1:0]  idx_val,
  output logic [COMP_W-1:0] comp_val,
  output logic              rd_ack
);
  localparam int BE_W   = DATA_W / 8;
  localparam int SLOT_W = ADDR_W - 2;

  logic              full_word;
  logic              aligned;
  logic              wr_ok;
  logic [SLOT_W-1:0] slot;

  assign full_word = (bus_be == {BE_W{1'b1}});
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign slot      = bus_addr[ADDR_W-1:2];
  assign wr_ok     = bus_valid && bus_write && full_word && aligned;

  assign idx_we   = wr_ok && (slot == SLOT_W'(IDX_SLOT));
  assign dat_we   = wr_ok && (slot == SLOT_W'(DAT_SLOT));
  assign idx_val  = bus_wdata[DATA_W-1 -: IDX_W];
  assign comp_val = bus_wdata[DATA_W-1 -: COMP_W];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_ack <= 1'b0;
    else        rd_ack <= bus_valid && !bus_write;
  end

  p_read_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_ack);
  p_no_ack_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |=> !rd_ack);
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_we,
  input  logic                dat_we,
  input  logic [IDX_W-1:0]    idx_val,
  output logic [IDX_W-1:0]    cur_idx,
  output logic [NUM_COMP-1:0] comp_we
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  phase_t phase;

  assign comp_we = dat_we ? phase_sel(phase) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx <= '0;
      phase   <= PH_RED;
    end else if (idx_we) begin
      cur_idx <= idx_val;
      phase   <= PH_RED;
    end else if (dat_we) begin
      case (phase)
        PH_RED: phase <= PH_GRN;
        PH_GRN: phase <= PH_BLU;
        default: begin
          phase   <= PH_RED;
          cur_idx <= (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
        end
      endcase
    end
  end

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> cur_idx == $past(idx_val));
  p_phase_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> phase == PH_RED);
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && phase == PH_RED) |=> phase == PH_GRN);
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && phase == PH_BLU) |=>
      (phase == PH_RED &&
       cur_idx == (($past(cur_idx) == LAST) ? '0 : $past(cur_idx) + 1'b1)));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_we && !dat_we) |=> ($stable(cur_idx) && $stable(phase)));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int COMP_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_COMP-1:0]        comp_we,
  input  logic [IDX_W-1:0]           waddr,
  input  logic [COMP_W-1:0]          wval,
  input  logic [IDX_W-1:0]           lut_idx,
  output logic [NUM_COMP*COMP_W-1:0] lut_rgb
);
  p_one_component_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < ENTRIES; i++)
          mem[i] <= (i == ENTRIES - 1) ? {COMP_W{1'b1}} : {COMP_W{1'b0}};
      end else if (comp_we[c]) begin
        mem[waddr] <= wval;
      end
    end

    // red lands in the top byte, blue in the bottom byte
    assign lut_rgb[(NUM_COMP-1-c)*COMP_W +: COMP_W] = mem[lut_idx];

    p_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      comp_we[c] |=> mem[$past(waddr)] == $past(wval));
  end
endmodule

// File: rtl/clut_ramdac.sv
module clut_ramdac
  import clut_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int ENTRIES  = 256,
  parameter int COMP_W   = 8,
  parameter int IDX_SLOT = 0,
  parameter int DAT_SLOT = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  output logic                       bus_ready,
  input  logic                       bus_write,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W/8-1:0]        bus_be,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_rvalid,
  input  logic [$clog2(ENTRIES)-1:0] lut_idx,
  output logic [NUM_COMP*COMP_W-1:0] lut_rgb
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int SLOT_W = ADDR_W - 2;

  logic                idx_we;
  logic                dat_we;
  logic [IDX_W-1:0]    idx_val;
  logic [COMP_W-1:0]   comp_val;
  logic [IDX_W-1:0]    cur_idx;
  logic [NUM_COMP-1:0] comp_we;

  assign bus_ready = 1'b1;
  assign bus_rdata = '0;

  clut_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .COMP_W(COMP_W),
    .IDX_SLOT(IDX_SLOT), .DAT_SLOT(DAT_SLOT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .idx_we(idx_we), .dat_we(dat_we), .idx_val(idx_val),
    .comp_val(comp_val), .rd_ack(bus_rvalid)
  );

  clut_seq #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .idx_we(idx_we), .dat_we(dat_we), .idx_val(idx_val),
    .cur_idx(cur_idx), .comp_we(comp_we)
  );

  clut_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .comp_we(comp_we), .waddr(cur_idx), .wval(comp_val),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  p_partial_keeps_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && (bus_be != {(DATA_W/8){1'b1}} || bus_addr[1:0] != 2'b00))
      |=> cur_idx == $past(cur_idx));
  p_other_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[ADDR_W-1:2] != SLOT_W'(IDX_SLOT)
     && bus_addr[ADDR_W-1:2] != SLOT_W'(DAT_SLOT)) |=> $stable(cur_idx));
  p_read_keeps_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> $stable(cur_idx));
endmodule

// File: tb/clut_ramdac_test.sv
module clut_ramdac_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_ph;

  always #10 clk = ~clk;

  clut_ramdac uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb)
  );

  function automatic logic [23:0] exp_rgb(input logic [7:0] i);
    return {m_r[i], m_g[i], m_b[i]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_r[i] = (i == 255) ? 8'hFF : 8'h00;
      m_g[i] = m_r[i];
      m_b[i] = m_r[i];
    end
    m_idx = '0;
    m_ph  = 0;
  endtask

  task automatic model_apply(input logic wr, input logic [3:0] a,
                             input logic [3:0] be, input logic [31:0] d);
    if (wr && be == 4'hF && a[1:0] == 2'b00) begin
      if (a[3:2] == 2'd0) begin
        m_idx = d[31:24];
        m_ph  = 0;
      end else if (a[3:2] == 2'd1) begin
        case (m_ph)
          0: begin m_r[m_idx] = d[31:24]; m_ph = 1; end
          1: begin m_g[m_idx] = d[31:24]; m_ph = 2; end
          default: begin m_b[m_idx] = d[31:24]; m_ph = 0; m_idx = m_idx + 8'd1; end
        endcase
      end
    end
  endtask

  task automatic bus_op(input logic wr, input logic [3:0] a,
                        input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    chk(bus_ready == 1'b1, "R7 ready", {31'd0, bus_ready}, 32'd1);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    model_apply(wr, a, be, d);
    if (!wr) begin
      chk(bus_rvalid == 1'b1, "R7 rvalid", {31'd0, bus_rvalid}, 32'd1);
      chk(bus_rdata == 32'd0, "R7 rdata", bus_rdata, 32'd0);
    end
  endtask

  task automatic wr_idx(input logic [7:0] v);
    bus_op(1'b1, 4'h0, 4'hF, {v, 24'h5A5A5A});
  endtask

  task automatic wr_col(input logic [7:0] v);
    bus_op(1'b1, 4'h4, 4'hF, {v, 24'hA5A5A5});
  endtask

  task automatic chk_entry(input logic [7:0] i, input string req);
    lut_idx = i;
    #1;
    chk(lut_rgb == exp_rgb(i), req, {8'd0, lut_rgb}, {8'd0, exp_rgb(i)});
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 256; i++) chk_entry(8'(i), req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_rvalid == 1'b0, "R7 reset rvalid", {31'd0, bus_rvalid}, 32'd0);
    sweep("R1 reset table");

    // R3: RGB order, then R4: advance and wrap past 255
    wr_idx(8'd254);
    wr_col(8'h11); chk_entry(8'd254, "R3 red first");
    wr_col(8'h22); chk_entry(8'd254, "R3 green second");
    wr_col(8'h33); chk_entry(8'd254, "R3 blue third");
    wr_col(8'h44); wr_col(8'h55); wr_col(8'h66);
    chk_entry(8'd255, "R4 advance to 255");
    wr_col(8'h77); wr_col(8'h88); wr_col(8'h99);
    chk_entry(8'd0, "R4 wrap to 0");

    // R2: pointer rewrite mid-triplet restarts at red
    wr_idx(8'd10); wr_col(8'hAA);
    wr_idx(8'd10); wr_col(8'hBB);
    chk_entry(8'd10, "R2 restart at red");
    wr_col(8'hCC);
    chk_entry(8'd10, "R2 green after restart");

    // R6: partial enables and misaligned address ignored
    bus_op(1'b1, 4'h4, 4'b0111, 32'hEE00_0000);
    bus_op(1'b1, 4'h5, 4'hF, 32'hEF00_0000);
    bus_op(1'b1, 4'h0, 4'b1110, 32'h3300_0000);
    chk_entry(8'd10, "R6 ignored writes");
    wr_col(8'hDD);
    chk_entry(8'd10, "R6 blue still pending");

    // R5: other offsets ignored; R7: reads leave state alone
    bus_op(1'b1, 4'h8, 4'hF, 32'h7700_0000);
    bus_op(1'b1, 4'hC, 4'hF, 32'h0100_0000);
    bus_op(1'b0, 4'h4, 4'hF, 32'h0);
    bus_op(1'b0, 4'h0, 4'hF, 32'h0);
    wr_col(8'h5A);
    chk_entry(8'd11, "R5 R7 next red at 11");
    chk_entry(8'd12, "R5 entry 12 untouched");

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0:       wr_idx(8'($urandom));
        1:       wr_idx(8'(250 + $urandom % 6));
        2,3,4,5: wr_col(8'($urandom));
        6:       bus_op(1'b1, {1'b1, 1'($urandom), 2'b00}, 4'hF, $urandom);
        7:       bus_op(1'b1, 4'($urandom), 4'($urandom % 15), $urandom);
        8:       bus_op(1'b1, {2'($urandom), 2'($urandom % 3 + 1)}, 4'hF, $urandom);
        default: bus_op(1'b0, 4'($urandom), 4'($urandom), $urandom);
      endcase
      chk_entry(m_idx, "R3 R4 random current");
      chk_entry(m_idx - 8'd1, "R4 random previous");
      chk_entry(8'($urandom), "R8 random lookup");
    end
    sweep("R8 final table");

    // R1 again after a second reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    sweep("R1 second reset");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule